// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

A system watchdog peripheral on a plain register bus. Software programs a 16-bit reload count, the expiry action and an optional clock divider in one control word, and that first control write arms the block. From then on a down-counter runs. A slower divided tick can clock it instead of the input clock. Software keeps it from running out by writing two fixed 16-bit key values, one after the other, to a halfword service register. When the count runs out, the block either pulses a reset request or raises an interrupt. The interrupt stays high until the next valid key pair.

The control word is accepted once per reset. Later writes to it have no effect, so a running watchdog cannot be stopped, slowed or switched to the other action. The enable bit reads back as the state the hardware actually holds. Software can therefore find out whether the watchdog really started.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the control word (offset 0x4) and the count (offset 0x8) both read 0, and reset_req and wd_irq are low.
- R2: The first write to offset 0x4 after reset captures reload count = bits 31:16, run enable = bit 2, action select = bit 1 (1 = reset request, 0 = interrupt) and divider enable = bit 0. Readback gives these fields in the same positions. Bit 3 reads as the expiry flag, and a written value in bit 3 is not stored. Every later control write is ignored.
- R3: From the edge that captures an enabling control word, the count reads the reload value. Without the divider it then drops by one on every clock. Writes to offset 0x8 do not change it.
- R4: With the divider enabled, the count drops by one every PRE_DIV clocks. The first drop comes PRE_DIV clocks after arming.
- R5: A write of 0x556C and then 0xAA39 to offset 0xE (data in bits 15:0) reloads the count with the reload value on the edge of the second write. Reads, and writes to other offsets, between the two keys do not break the pair.
- R6: A service write of any value other than the expected next key returns the checker to waiting for 0x556C. A 0x556C write always counts as a first key. 0xAA39 without a pending first key does not reload.
- R7: In reset action, the edge that would take the count below 1 instead reloads it and drives reset_req high for exactly that one cycle.
- R8: In interrupt action, expiry raises wd_irq. It stays high over further expiries, clears on the edge of a valid key pair, and reset_req stays low.
- R9: A reload count of 0 means 65536. The count reads 0x10000 right after arming.
- R10: If the second key lands on the same edge as an expiry, the reload wins and no expiry action occurs.
- R11: Control bit 3 reads 1 from the first expiry until the next reset, whatever the servicing.
- R12: A first control word with bit 2 clear reads back with bit 2 = 0 and leaves the count at 0. Because that word is the only one accepted, a later enabling write does not start the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset within the block |
| wdata | input | 32 | Write data (service key in bits 15:0) |
| rdata | output | 32 | Read data for addr, combinational |
| reset_req | output | 1 | One-cycle reset request on expiry in reset action |
| wd_irq | output | 1 | Level interrupt on expiry in interrupt action |

## Verification
A valid service and an expiry can land on the same clock edge. The bench provokes this by arming a short reload count and sending the first key early. It then times the second key so that its edge is the one where the count reads 1. It judges the result by the count reading the full reload value after that edge, with reset_req and the expiry flag still low one and two cycles later. Randomly drawn key streams, checked against a model of the key checker inside the bench, cover the other interactions between servicing and counting.

// File: rtl/wd_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a 32-bit register bus with byte offsets on a 4-bit address.
package wd_pkg;
    localparam int TMO_W = 16;

    localparam logic [3:0] OFS_CTRL  = 4'h4;
    localparam logic [3:0] OFS_COUNT = 4'h8;
    localparam logic [3:0] OFS_SVC   = 4'hE;

    localparam logic [15:0] KEY_FIRST  = 16'h556C;
    localparam logic [15:0] KEY_SECOND = 16'hAA39;

    localparam int BIT_FLAG = 3;
    localparam int BIT_RUN  = 2;
    localparam int BIT_ACT  = 1;
    localparam int BIT_DIV  = 0;

    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic             run;
        logic             act_rst;
        logic             div_on;
    } wd_cfg_t;

    typedef enum logic {
        KS_WAIT_FIRST  = 1'b0,
        KS_WAIT_SECOND = 1'b1
    } key_state_t;
endpackage

// File: rtl/wd_cfg_reg.sv
// Write-once control register. The first control write after reset is
// captured and locks the register; later writes are dropped.
// Assumes wr is already decoded for the control offset.
module wd_cfg_reg
    import wd_pkg::*;
#(
    parameter bit RUN_ALLOWED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [31:0]      wdata,
    output wd_cfg_t          cfg,
    output logic             arm,
    output logic [TMO_W-1:0] arm_tmo
);
    logic locked_q;

    // Start the counter on the accepted write that sets the run bit.
    always_comb begin
        arm     = wr && !locked_q && wdata[BIT_RUN] && RUN_ALLOWED;
        arm_tmo = wdata[31:16];
    end

    // Capture the first control word and lock against further writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            locked_q <= 1'b0;
        end else if (wr && !locked_q) begin
            locked_q    <= 1'b1;
            cfg.tmo     <= wdata[31:16];
            cfg.run     <= wdata[BIT_RUN] & RUN_ALLOWED;
            cfg.act_rst <= wdata[BIT_ACT];
            cfg.div_on  <= wdata[BIT_DIV];
        end
    end

    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(cfg));
    p_run_needs_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.run |-> locked_q);
endmodule

// File: rtl/wd_key_seq.sv
// Service key checker: recognises the first key followed by the second key
// on consecutive service writes and pulses kick on the second.
// Assumes wr is decoded for the service offset; other traffic never reaches it.
module wd_key_seq
    import wd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [15:0] key,
    output logic        kick
);
    key_state_t st_q;

    // Kick when the pending first key is followed by the second key.
    always_comb kick = wr && (st_q == KS_WAIT_SECOND) && (key == KEY_SECOND);

    // Track whether a first key is pending; anything else starts over.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= KS_WAIT_FIRST;
        else if (wr)
            st_q <= (key == KEY_FIRST) ? KS_WAIT_SECOND : KS_WAIT_FIRST;
    end

    p_kick_rearms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> st_q == KS_WAIT_FIRST);
endmodule

// File: rtl/wd_count.sv
// Down-counter with optional tick divider and expiry actions.
// Assumes PRE_DIV >= 2 and that arm occurs at most once per reset.
module wd_count
    import wd_pkg::*;
#(
    parameter int PRE_DIV = 65536,
    localparam int PW = $clog2(PRE_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [TMO_W-1:0] arm_tmo,
    input  wd_cfg_t          cfg,
    input  logic             kick,
    output logic [TMO_W:0]   cnt_q,
    output logic             reset_req,
    output logic             wd_irq,
    output logic             expired
);
    localparam logic [PW-1:0]  PRE_LAST = PW'(PRE_DIV - 1);
    localparam logic [TMO_W:0] ONE      = (TMO_W+1)'(1);

    logic [PW-1:0] pre_q;
    logic          tick;
    logic          service;
    logic          fire;

    // Reload value: zero stands for the full 2^TMO_W count.
    function automatic logic [TMO_W:0] span(input logic [TMO_W-1:0] t);
        return (t == '0) ? {1'b1, {TMO_W{1'b0}}} : {1'b0, t};
    endfunction

    // Decrement enable, valid service and expiry decisions.
    always_comb begin
        service = cfg.run && kick;
        tick    = cfg.run && (!cfg.div_on || pre_q == PRE_LAST);
        fire    = tick && !service && !arm && (cnt_q == ONE);
    end

    // Divider phase; restarts on arming and on every valid service.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (arm || service || !cfg.div_on)
            pre_q <= '0;
        else if (cfg.run)
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end

    // Count: load on arm, reload on service or expiry, else step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (arm)
            cnt_q <= span(arm_tmo);
        else if (service || fire)
            cnt_q <= span(cfg.tmo);
        else if (tick)
            cnt_q <= cnt_q - ONE;
    end

    // Expiry actions: reset pulse, level interrupt and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
            wd_irq    <= 1'b0;
            expired   <= 1'b0;
        end else begin
            reset_req <= fire && cfg.act_rst;
            if (service)
                wd_irq <= 1'b0;
            else if (fire && !cfg.act_rst)
                wd_irq <= 1'b1;
            if (fire)
                expired <= 1'b1;
        end
    end

    p_running_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.run |-> cnt_q != '0);
    p_service_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && cfg.run) |=> cnt_q == span(cfg.tmo));
    p_pulse_reset_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> cfg.act_rst);
    p_irq_int_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> !cfg.act_rst);
    p_irq_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && cfg.run) |=> !wd_irq);
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired);
endmodule

// File: rtl/keyed_watchdog.sv
// Keyed-service watchdog top: decodes the register bus and connects the
// write-once control register, the key checker and the counter.
// Assumes single-cycle writes and combinational reads on addr.
module keyed_watchdog
    import wd_pkg::*;
#(
    parameter int PRE_DIV     = 65536,
    parameter bit RUN_ALLOWED = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        reset_req,
    output logic        wd_irq
);
    wd_cfg_t          cfg;
    logic             arm;
    logic [TMO_W-1:0] arm_tmo;
    logic             kick;
    logic [TMO_W:0]   cnt;
    logic             expired;
    logic             wr_ctrl;
    logic             wr_svc;

    // Write decode per register offset.
    always_comb begin
        wr_ctrl = wr_en && (addr == OFS_CTRL);
        wr_svc  = wr_en && (addr == OFS_SVC);
    end

    wd_cfg_reg #(.RUN_ALLOWED(RUN_ALLOWED)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_ctrl),
        .wdata  (wdata),
        .cfg    (cfg),
        .arm    (arm),
        .arm_tmo(arm_tmo)
    );

    wd_key_seq u_keys (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (wr_svc),
        .key  (wdata[15:0]),
        .kick (kick)
    );

    wd_count #(.PRE_DIV(PRE_DIV)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .arm_tmo  (arm_tmo),
        .cfg      (cfg),
        .kick     (kick),
        .cnt_q    (cnt),
        .reset_req(reset_req),
        .wd_irq   (wd_irq),
        .expired  (expired)
    );

    // Read mux: control word with live flag, or zero-extended count.
    always_comb begin
        case (addr)
            OFS_CTRL:  rdata = {cfg.tmo, 12'h000, expired, cfg.run,
                                cfg.act_rst, cfg.div_on};
            OFS_COUNT: rdata = {{(31-TMO_W){1'b0}}, cnt};
            default:   rdata = 32'h0;
        endcase
    end
endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
    localparam int DIV = 8;
    localparam logic [15:0] K1 = 16'h556C;
    localparam logic [15:0] K2 = 16'hAA39;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        reset_req;
    logic        wd_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    keyed_watchdog #(.PRE_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .reset_req(reset_req), .wd_irq(wd_irq)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    function automatic logic [31:0] span_of(input logic [15:0] t);
        return (t == 16'h0) ? 32'h10000 : {16'h0, t};
    endfunction
    function automatic logic [31:0] ctrl_word(input logic [15:0] t, input bit run,
                                              input bit act, input bit dv);
        return {t, 12'h0, 1'b0, run, act, dv};
    endfunction
    function automatic bit key_kicks(input bit pend, input logic [15:0] k);
        return pend && (k == K2);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge; returns at the negedge after it.
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'h0;
    endtask
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; #0.5; d = rdata;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0; idle(2); rst_n = 1'b1;
    endtask

    logic [31:0] v;

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R1: reset state
        rd(4'h4, v); chk("R1 ctrl", v, 32'h0);
        rd(4'h8, v); chk("R1 count", v, 32'h0);
        chk("R1 reset_req", {31'h0, reset_req}, 32'h0);
        chk("R1 wd_irq", {31'h0, wd_irq}, 32'h0);

        // R2/R3: capture, bit 3 dropped, later writes ignored, count writes ignored
        bus_wr(4'h4, 32'h0028_000E);
        rd(4'h4, v); chk("R2 readback", v, 32'h0028_0006);
        rd(4'h8, v); chk("R3 load", v, 32'd40);
        bus_wr(4'h4, 32'h0000_0000);
        rd(4'h4, v); chk("R2 second write ignored", v, 32'h0028_0006);
        bus_wr(4'h8, 32'h0000_FFFF);
        rd(4'h8, v); chk("R3 count write ignored", v, 32'd38);
        idle(5);
        rd(4'h8, v); chk("R3 decrement", v, 32'd33);

        // R5: key pair with traffic in between
        bus_wr(4'hE, {16'h0, K1});
        rd(4'h4, v);
        bus_wr(4'h0, 32'h1234_5678);
        bus_wr(4'h4, 32'h0001_0007);
        bus_wr(4'hE, {16'h0, K2});
        rd(4'h8, v); chk("R5 reload after interleaved traffic", v, 32'd40);

        // R6: lone second key, broken pair, repeated first key
        bus_wr(4'hE, {16'h0, K2});
        rd(4'h8, v); chk("R6 lone second key", v, 32'd39);
        bus_wr(4'hE, {16'h0, K1});
        bus_wr(4'hE, 32'h0000_1111);
        bus_wr(4'hE, {16'h0, K2});
        rd(4'h8, v); chk("R6 broken pair", v, 32'd36);
        bus_wr(4'hE, {16'h0, K1});
        bus_wr(4'hE, {16'h0, K1});
        bus_wr(4'hE, {16'h0, K2});
        rd(4'h8, v); chk("R6 repeated first key", v, 32'd40);

        // R7/R11: reset action pulse and sticky flag
        do_reset();
        bus_wr(4'h4, ctrl_word(16'd5, 1, 1, 0));
        chk("R7 low at arm", {31'h0, reset_req}, 32'h0);
        idle(4);
        rd(4'h8, v); chk("R7 count before expiry", v, 32'd1);
        chk("R7 low before expiry", {31'h0, reset_req}, 32'h0);
        idle(1);
        chk("R7 pulse", {31'h0, reset_req}, 32'h1);
        rd(4'h8, v); chk("R7 reload on expiry", v, 32'd5);
        rd(4'h4, v); chk("R11 flag set", v, 32'h0005_000E);
        idle(1);
        chk("R7 pulse ends", {31'h0, reset_req}, 32'h0);
        bus_wr(4'hE, {16'h0, K1});
        bus_wr(4'hE, {16'h0, K2});
        rd(4'h4, v); chk("R11 flag survives service", v, 32'h0005_000E);
        chk("R8 no irq in reset action", {31'h0, wd_irq}, 32'h0);

        // R8: interrupt action
        do_reset();
        bus_wr(4'h4, ctrl_word(16'd4, 1, 0, 0));
        idle(3);
        chk("R8 irq low before expiry", {31'h0, wd_irq}, 32'h0);
        idle(1);
        chk("R8 irq raised", {31'h0, wd_irq}, 32'h1);
        idle(10);
        chk("R8 irq held", {31'h0, wd_irq}, 32'h1);
        chk("R8 no reset request", {31'h0, reset_req}, 32'h0);
        bus_wr(4'hE, {16'h0, K1});
        bus_wr(4'hE, {16'h0, K2});
        chk("R8 irq cleared", {31'h0, wd_irq}, 32'h0);
        rd(4'h8, v); chk("R8 reload", v, 32'd4);

        // R9: zero reload count
        do_reset();
        bus_wr(4'h4, ctrl_word(16'd0, 1, 1, 0));
        rd(4'h8, v); chk("R9 full count", v, 32'h10000);
        idle(1);
        rd(4'h8, v); chk("R9 first step", v, 32'h0FFFF);

        // R4: divider
        do_reset();
        bus_wr(4'h4, ctrl_word(16'd3, 1, 1, 1));
        idle(DIV - 1);
        rd(4'h8, v); chk("R4 held within period", v, 32'd3);
        idle(1);
        rd(4'h8, v); chk("R4 first step", v, 32'd2);
        idle(2*DIV - 1);
        rd(4'h8, v); chk("R4 at one", v, 32'd1);
        chk("R4 no early pulse", {31'h0, reset_req}, 32'h0);
        idle(1);
        chk("R4 pulse after 3 periods", {31'h0, reset_req}, 32'h1);

        // R10: service on the expiry edge
        do_reset();
        bus_wr(4'h4, ctrl_word(16'd6, 1, 1, 0));
        bus_wr(4'hE, {16'h0, K1});
        idle(4);
        rd(4'h8, v); chk("R10 count at one", v, 32'd1);
        bus_wr(4'hE, {16'h0, K2});
        rd(4'h8, v); chk("R10 reload wins", v, 32'd6);
        chk("R10 no pulse", {31'h0, reset_req}, 32'h0);
        idle(1);
        chk("R10 no late pulse", {31'h0, reset_req}, 32'h0);
        rd(4'h4, v); chk("R10 flag clear", v, 32'h0006_0006);

        // R12: first word without run bit
        do_reset();
        bus_wr(4'h4, 32'h0005_0002);
        rd(4'h4, v); chk("R12 readback", v, 32'h0005_0002);
        idle(10);
        rd(4'h8, v); chk("R12 idle count", v, 32'h0);
        bus_wr(4'h4, ctrl_word(16'd5, 1, 1, 0));
        rd(4'h4, v); chk("R12 stays stopped", v, 32'h0005_0002);
        idle(3);
        rd(4'h8, v); chk("R12 count still zero", v, 32'h0);

        // R5/R6 random key streams against a bench model
        for (int trial = 0; trial < 20; trial++) begin
            logic [31:0] exp_cnt;
            bit pend;
            logic [15:0] t;
            t = 16'(300 + $urandom_range(0, 200));
            do_reset();
            bus_wr(4'h4, ctrl_word(t, 1, 1, 0));
            exp_cnt = span_of(t);
            pend = 1'b0;
            for (int w = 0; w < 8; w++) begin
                logic [15:0] k;
                int pick;
                pick = $urandom_range(0, 2);
                k = (pick == 0) ? K1 : (pick == 1) ? K2 : 16'($urandom);
                bus_wr(4'hE, {16'h0, k});
                exp_cnt = key_kicks(pend, k) ? span_of(t) : exp_cnt - 1;
                pend = (k == K1);
                rd(4'h8, v); chk("R5 R6 random key stream", v, exp_cnt);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule